// File: doc/BRIEF.md
# Buffered SPI Transfer-Group Sequencer

This block is an SPI master that plays back a sequence of byte transfers held in a small entry buffer. Every entry has a transmit half and a receive half. The transmit half holds a 16-bit control word and a data word. The receive half holds the byte captured from the slave and two status flags. Software fills the entries through a simple word port. It then names a transfer group by its first entry index and its length, and pulses a trigger. The sequencer visits the entries in ascending order. For each entry it drives that entry's chip-select mask, shifts one byte in SPI mode 0 with the most significant bit first, and stores the received byte. When the whole group is done it raises a sticky completion flag.

Each entry carries its own flow-control rule, called the readiness mode. The sequencer stalls on an entry that is not ready and resumes on its own once software writes the transmit data or reads the receive data that the entry is waiting for. A multi-byte command keeps chip select low across its bytes by setting the hold bit on every entry except the last. An optional per-entry wait inserts a fixed number of idle cycles after the byte.

The controller has five states:
- `S_IDLE` goes to `S_CHECK` on a trigger with a non-zero length. A zero-length trigger sets the done flag and the controller stays in `S_IDLE`.
- `S_CHECK` goes to `S_SHIFT` when the entry is ready, and goes to `S_ADVANCE` when the entry's mode is disabled. Otherwise it stays in `S_CHECK`, which is the stall.
- `S_SHIFT` leaves when the byte completes. It goes to `S_DELAY` if the entry's wait bit is set, and to `S_ADVANCE` if not.
- `S_DELAY` goes to `S_ADVANCE` after the wait count.
- `S_ADVANCE` goes to `S_IDLE` after the last entry, and back to `S_CHECK` otherwise.

Top module: `spi_group_seq`

## Requirements
- R1: After reset, all chip-select lines are high, the serial clock and data-out are low, the done flag is 0, and every receive entry reads 32'h8000_0000 (empty, no overrun, data 0).
- R2: Each transferred entry shifts out bits [7:0] of its data word in SPI mode 0, most significant bit first. The slave byte is stored in bits [7:0] of the receive entry. Data bits [15:8] and control bits [12:10] (format select and lock) have no effect.
- R3: While an entry's byte is on the bus, the chip-select outputs equal control bits [7:0] of that entry. They do not change during the byte, and the serial clock never pulses while all lines are high.
- R4: If control bit 8 (hold) is set, chip select goes straight on into the next entry with no all-high cycle. If it is clear, all lines go high for at least one cycle after the entry. All lines are high once the group ends.
- R5: A trigger transfers grp_len entries starting at grp_start, in ascending order, wrapping from the last entry to entry 0. A length of 0 sets the done flag without any bus activity.
- R6: In mode 7 (control bits [15:13] = 3'b111), an entry waits until its data word has been written since its last transfer and its receive entry has been read. Until then no byte is sent and the group does not finish.
- R7: In mode 4 (3'b100), an entry waits only for a fresh data write. If the earlier receive byte was never read, status bit 30 (overrun) is set.
- R8: In mode 5 (3'b101), an entry never waits. It resends the stored data if that data was not rewritten, and it sets overrun when it overwrites an unread receive byte.
- R9: An entry with any other mode value is skipped. No byte is sent and its receive entry is unchanged.
- R10: Receive status bit 31 (empty) clears when the entry's byte is captured. Reading the entry with sw_rx_re sets it again and clears overrun.
- R11: When control bit 9 is set, WAIT_CYCLES idle clock cycles follow the entry's byte. During them chip select keeps its level and the serial clock stays low.
- R12: The done flag is set when the group ends. It stays set until grp_done_clr is pulsed, and a new completion takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_addr | input | IDX_W | Entry index for software access |
| sw_wdata | input | 16 | Write data for a control or data word |
| sw_ctrl_we | input | 1 | Write the control word of entry sw_addr |
| sw_data_we | input | 1 | Write the data word of entry sw_addr and mark it fresh |
| sw_rx_re | input | 1 | Read acknowledge: marks receive entry sw_addr as consumed |
| sw_rx_rdata | output | 32 | Receive entry sw_addr: {empty, overrun, 22'b0, byte} |
| grp_start | input | IDX_W | First entry of the group |
| grp_len | input | IDX_W+1 | Number of entries in the group |
| grp_trig | input | 1 | Start pulse, ignored while a group runs |
| grp_done_clr | input | 1 | Clear pulse for the done flag |
| grp_done | output | 1 | Sticky group-complete flag |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | CS_W | Active-low chip-select lines |

## Verification
A wrong readiness decision shows up at once as a byte that appears too early on spi_mosi, or as a group that never sets grp_done. The bench detects the missing byte within the 200-cycle observation window it allows before releasing a stall. A corrupted index or length counter shows up on the byte log within one entry time: the bytes come out in the wrong order, in the wrong number, or with the wrong chip-select mask. Faults in the hold or wait logic show up at the next entry boundary, either as an all-high gap on chip select or as a group duration that is off by the wait count.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_SHIFT,
        S_DELAY,
        S_ADVANCE
    } seq_state_t;

    // Per-entry control word, MSB first: mode, format, lock, wait, hold, mask
    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] fmt;
        logic       lock;
        logic       wdel;
        logic       hold;
        logic [7:0] mask;
    } entry_ctrl_t;

    localparam logic [2:0] MODE_TXONLY = 3'd4;
    localparam logic [2:0] MODE_FREE   = 3'd5;
    localparam logic [2:0] MODE_FULL   = 3'd7;

endpackage

// File: rtl/spi_seq_bufram.sv
module spi_seq_bufram
    import spi_seq_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sw_addr,
    input  logic [15:0]       sw_wdata,
    input  logic              sw_ctrl_we,
    input  logic              sw_data_we,
    input  logic              sw_rx_re,
    output logic [31:0]       sw_rx_rdata,
    input  logic [IDX_W-1:0]  seq_idx,
    output entry_ctrl_t       seq_ctrl,
    output logic [7:0]        seq_txbyte,
    output logic              seq_tx_upd,
    output logic              seq_rx_full,
    input  logic              consume,
    input  logic              cap_we,
    input  logic [7:0]        cap_data
);

    logic [15:0] ctrl_all [N];
    logic [7:0]  txd_all  [N];
    logic        upd_all  [N];
    logic [7:0]  rxd_all  [N];
    logic        full_all [N];
    logic        ovr_all  [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_entry
        logic [15:0] ctrl_r;
        logic [7:0]  txd_r;
        logic        upd_r;
        logic [7:0]  rxd_r;
        logic        full_r;
        logic        ovr_r;
        logic        sel_sw;
        logic        sel_seq;

        assign sel_sw  = (sw_addr == IDX_W'(gi));
        assign sel_seq = (seq_idx == IDX_W'(gi));

        // Transmit half: software write marks the data fresh, a transfer start consumes it
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_r <= '0;
                txd_r  <= '0;
                upd_r  <= 1'b0;
            end else begin
                if (sw_ctrl_we && sel_sw) begin
                    ctrl_r <= sw_wdata;
                end
                if (consume && sel_seq) begin
                    upd_r <= 1'b0;
                end
                if (sw_data_we && sel_sw) begin
                    txd_r <= sw_wdata[7:0];
                    upd_r <= 1'b1;
                end
            end
        end

        // Receive half: capture fills the entry, a software read empties it
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rxd_r  <= '0;
                full_r <= 1'b0;
                ovr_r  <= 1'b0;
            end else if (cap_we && sel_seq) begin
                rxd_r  <= cap_data;
                ovr_r  <= full_r;
                full_r <= 1'b1;
            end else if (sw_rx_re && sel_sw) begin
                full_r <= 1'b0;
                ovr_r  <= 1'b0;
            end
        end

        assign ctrl_all[gi] = ctrl_r;
        assign txd_all[gi]  = txd_r;
        assign upd_all[gi]  = upd_r;
        assign rxd_all[gi]  = rxd_r;
        assign full_all[gi] = full_r;
        assign ovr_all[gi]  = ovr_r;
    end

    assign sw_rx_rdata = {~full_all[sw_addr], ovr_all[sw_addr], 22'd0, rxd_all[sw_addr]};
    assign seq_ctrl    = entry_ctrl_t'(ctrl_all[seq_idx]);
    assign seq_txbyte  = txd_all[seq_idx];
    assign seq_tx_upd  = upd_all[seq_idx];
    assign seq_rx_full = full_all[seq_idx];

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int CNT_W = $clog2(HALF) + 1;

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitc;
    logic [7:0]       sh;

    // Mode 0: sample on the rising edge, shift on the falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            bitc    <= '0;
            sh      <= '0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= tx_byte;
                cnt    <= '0;
                bitc   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt == CNT_W'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitc == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitc <= bitc + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign mosi = active & sh[7];

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_seq_pkg::*;
#(
    parameter int N           = 16,
    parameter int CS_W        = 8,
    parameter int WAIT_CYCLES = 4,
    parameter int IDX_W       = 4,
    parameter int LEN_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_trig,
    input  logic [IDX_W-1:0] grp_start,
    input  logic [LEN_W-1:0] grp_len,
    input  logic             grp_done_clr,
    input  entry_ctrl_t      ent,
    input  logic             ent_tx_upd,
    input  logic             ent_rx_full,
    input  logic             shift_done,
    output logic [IDX_W-1:0] idx,
    output logic             shift_start,
    output logic             cap_we,
    output logic [CS_W-1:0]  cs_n,
    output logic             grp_done,
    output seq_state_t       state,
    output logic             fin
);

    localparam int DLY_W = $clog2(WAIT_CYCLES) + 1;

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] remain_q;
    logic [DLY_W-1:0] dly_q;
    logic             hold_q, wdel_q, xfer_q, done_q;
    logic [CS_W-1:0]  cs_q;
    logic             ready, skip, last, dly_end;

    // Readiness per entry mode
    always_comb begin
        ready = 1'b0;
        skip  = 1'b0;
        unique case (ent.mode)
            MODE_FULL:   ready = ent_tx_upd & ~ent_rx_full;
            MODE_TXONLY: ready = ent_tx_upd;
            MODE_FREE:   ready = 1'b1;
            default:     skip  = 1'b1;
        endcase
    end

    assign last    = (remain_q == LEN_W'(1));
    assign dly_end = (dly_q == DLY_W'(WAIT_CYCLES - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (grp_trig && grp_len != '0) state_d = S_CHECK;
            S_CHECK:   if (skip) state_d = S_ADVANCE;
                       else if (ready) state_d = S_SHIFT;
            S_SHIFT:   if (shift_done) state_d = wdel_q ? S_DELAY : S_ADVANCE;
            S_DELAY:   if (dly_end) state_d = S_ADVANCE;
            S_ADVANCE: state_d = last ? S_IDLE : S_CHECK;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Strobes
    assign shift_start = (state_q == S_CHECK) && !skip && ready;
    assign cap_we      = (state_q == S_SHIFT) && shift_done;
    assign fin         = ((state_q == S_ADVANCE) && last) ||
                         ((state_q == S_IDLE) && grp_trig && grp_len == '0);

    // Registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            remain_q <= '0;
            dly_q    <= '0;
            hold_q   <= 1'b0;
            wdel_q   <= 1'b0;
            xfer_q   <= 1'b0;
            cs_q     <= '1;
            done_q   <= 1'b0;
        end else begin
            if (fin)               done_q <= 1'b1;
            else if (grp_done_clr) done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (grp_trig) begin
                        idx_q    <= grp_start;
                        remain_q <= grp_len;
                    end
                end
                S_CHECK: begin
                    if (shift_start) begin
                        cs_q   <= ent.mask[CS_W-1:0];
                        hold_q <= ent.hold;
                        wdel_q <= ent.wdel;
                        xfer_q <= 1'b1;
                    end else if (skip) begin
                        xfer_q <= 1'b0;
                    end
                end
                S_SHIFT: dly_q <= '0;
                S_DELAY: dly_q <= dly_q + DLY_W'(1);
                S_ADVANCE: begin
                    if ((xfer_q && !hold_q) || last) cs_q <= '1;
                    remain_q <= remain_q - LEN_W'(1);
                    idx_q    <= (idx_q == IDX_W'(N - 1)) ? '0 : idx_q + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign idx      = idx_q;
    assign cs_n     = cs_q;
    assign grp_done = done_q;
    assign state    = state_q;

endmodule

// File: rtl/spi_group_seq.sv
module spi_group_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int CS_W        = 8,
    parameter int SCLK_HALF   = 2,
    parameter int WAIT_CYCLES = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int LEN_W      = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sw_addr,
    input  logic [15:0]      sw_wdata,
    input  logic             sw_ctrl_we,
    input  logic             sw_data_we,
    input  logic             sw_rx_re,
    output logic [31:0]      sw_rx_rdata,
    input  logic [IDX_W-1:0] grp_start,
    input  logic [LEN_W-1:0] grp_len,
    input  logic             grp_trig,
    input  logic             grp_done_clr,
    output logic             grp_done,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic [CS_W-1:0]  spi_cs_n
);

    entry_ctrl_t      ent;
    logic [7:0]       ent_txbyte, rx_byte;
    logic             ent_tx_upd, ent_rx_full;
    logic             shift_start, shift_done, cap_we, seq_fin;
    logic [IDX_W-1:0] seq_idx;
    seq_state_t       seq_state;

    spi_seq_bufram #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_ctrl_we(sw_ctrl_we), .sw_data_we(sw_data_we),
        .sw_rx_re(sw_rx_re), .sw_rx_rdata(sw_rx_rdata),
        .seq_idx(seq_idx), .seq_ctrl(ent), .seq_txbyte(ent_txbyte),
        .seq_tx_upd(ent_tx_upd), .seq_rx_full(ent_rx_full),
        .consume(shift_start), .cap_we(cap_we), .cap_data(rx_byte)
    );

    spi_seq_shift #(.HALF(SCLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(shift_start), .tx_byte(ent_txbyte),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(shift_done), .rx_byte(rx_byte)
    );

    spi_seq_fsm #(
        .N(NUM_ENTRIES), .CS_W(CS_W), .WAIT_CYCLES(WAIT_CYCLES),
        .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .grp_trig(grp_trig), .grp_start(grp_start), .grp_len(grp_len),
        .grp_done_clr(grp_done_clr),
        .ent(ent), .ent_tx_upd(ent_tx_upd), .ent_rx_full(ent_rx_full),
        .shift_done(shift_done), .idx(seq_idx), .shift_start(shift_start),
        .cap_we(cap_we), .cs_n(spi_cs_n), .grp_done(grp_done),
        .state(seq_state), .fin(seq_fin)
    );

endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker
    import spi_seq_pkg::*;
#(
    parameter int CS_W  = 8,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_sclk,
    input logic [CS_W-1:0]  spi_cs_n,
    input logic             sw_rx_re,
    input logic [IDX_W-1:0] sw_addr,
    input logic [31:0]      sw_rx_rdata,
    input logic             grp_done,
    input logic             grp_done_clr,
    input seq_state_t       state,
    input logic             fin,
    input logic             cap_we,
    input logic [IDX_W-1:0] cap_idx
);

    AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> (spi_cs_n != '1)); // R3

    AST_CS_STEADY_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && $past(state) == S_SHIFT) |-> $stable(spi_cs_n)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (spi_cs_n == '1 && !spi_sclk)); // R4

    AST_DELAY_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DELAY && $past(state) == S_DELAY) |-> ($stable(spi_cs_n) && !spi_sclk)); // R11

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rx_re && !(cap_we && cap_idx == sw_addr)) |=>
        ((sw_addr != $past(sw_addr)) || sw_rx_rdata[31])); // R10

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_done && !grp_done_clr) |=> grp_done); // R12

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_done_clr && !fin) |=> !grp_done); // R12

endmodule

bind spi_group_seq spi_seq_checker #(.CS_W(CS_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .sw_rx_re(sw_rx_re), .sw_addr(sw_addr), .sw_rx_rdata(sw_rx_rdata),
    .grp_done(grp_done), .grp_done_clr(grp_done_clr),
    .state(seq_state), .fin(seq_fin), .cap_we(cap_we), .cap_idx(seq_idx)
);

// File: tb/spi_group_seq_bench.sv
module spi_group_seq_bench;

    localparam int N    = 16;
    localparam int WAIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sw_addr = '0;
    logic [15:0] sw_wdata = '0;
    logic        sw_ctrl_we = 1'b0;
    logic        sw_data_we = 1'b0;
    logic        sw_rx_re = 1'b0;
    logic [31:0] sw_rx_rdata;
    logic [3:0]  grp_start = '0;
    logic [4:0]  grp_len = '0;
    logic        grp_trig = 1'b0;
    logic        grp_done_clr = 1'b0;
    logic        grp_done;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [7:0]  spi_cs_n;

    int vectors = 0;
    int miscomp = 0;

    always #2 clk = ~clk;

    spi_group_seq #(.NUM_ENTRIES(N), .CS_W(8), .SCLK_HALF(2), .WAIT_CYCLES(WAIT)) u_spi_group_seq (
        .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_ctrl_we(sw_ctrl_we), .sw_data_we(sw_data_we), .sw_rx_re(sw_rx_re),
        .sw_rx_rdata(sw_rx_rdata), .grp_start(grp_start), .grp_len(grp_len),
        .grp_trig(grp_trig), .grp_done_clr(grp_done_clr), .grp_done(grp_done),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Slave model: replies with a known byte sequence, logs what it receives
    function automatic logic [7:0] resp(int n);
        return 8'((n * 37 + 90) & 255);
    endfunction

    logic [7:0] sl = 8'd90;
    logic [7:0] cap = '0;
    int         sbits = 0;
    int         nbytes = 0;
    logic       rel = 1'b1;
    logic [7:0] log_byte [256];
    logic [7:0] log_cs   [256];
    logic       log_rel  [256];

    assign spi_miso = sl[7];

    always @(posedge spi_sclk) begin
        if (sbits == 0) begin
            log_cs[nbytes]  = spi_cs_n;
            log_rel[nbytes] = rel;
            rel = 1'b0;
        end
        cap = {cap[6:0], spi_mosi};
        sbits++;
        if (sbits == 8) begin
            log_byte[nbytes] = cap;
            nbytes++;
        end
    end

    always @(negedge spi_sclk) begin
        if (sbits == 8) begin
            sbits = 0;
            sl = resp(nbytes);
        end else begin
            sl = {sl[6:0], 1'b0};
        end
    end

    always @(negedge clk) if (spi_cs_n == 8'hFF) rel = 1'b1;

    // Expected entry contents
    logic [15:0] exp_ctrl [N];
    logic [7:0]  exp_data [N];

    function automatic logic [15:0] mk(logic [2:0] m, logic h, logic w, logic [7:0] msk, logic [2:0] junk);
        return {m, junk, w, h, msk};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(int i, logic [15:0] v);
        @(negedge clk); sw_addr = 4'(i); sw_wdata = v; sw_ctrl_we = 1'b1;
        @(negedge clk); sw_ctrl_we = 1'b0;
        exp_ctrl[i] = v;
    endtask

    task automatic wr_data(int i, logic [15:0] v);
        @(negedge clk); sw_addr = 4'(i); sw_wdata = v; sw_data_we = 1'b1;
        @(negedge clk); sw_data_we = 1'b0;
        exp_data[i] = v[7:0];
    endtask

    task automatic peek(int i, output logic [31:0] v);
        @(negedge clk); sw_addr = 4'(i); #1 v = sw_rx_rdata;
    endtask

    task automatic rd_rx(int i, output logic [31:0] v);
        @(negedge clk); sw_addr = 4'(i); #1 v = sw_rx_rdata; sw_rx_re = 1'b1;
        @(negedge clk); sw_rx_re = 1'b0;
    endtask

    task automatic trig(int s, int l);
        @(negedge clk); grp_start = 4'(s); grp_len = 5'(l); grp_trig = 1'b1;
        @(negedge clk); grp_trig = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!grp_done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!grp_done) chk("R12 done timeout", 0, 1);
    endtask

    task automatic clr_done();
        @(negedge clk); grp_done_clr = 1'b1;
        @(negedge clk); grp_done_clr = 1'b0;
    endtask

    task automatic run_group(int s, int l, output int cyc);
        int base;
        logic [31:0] v;
        base = nbytes;
        trig(s, l);
        wait_done(cyc);
        chk("R5 byte count", nbytes - base, l);
        for (int k = 0; k < l; k++) begin
            int e, p;
            e = (s + k) % N;
            p = (s + k + N - 1) % N;
            chk("R2 mosi byte", log_byte[base + k], exp_data[e]);
            chk("R3 cs mask", log_cs[base + k], exp_ctrl[e][7:0]);
            if (k > 0) chk("R4 hold gap", log_rel[base + k], !exp_ctrl[p][8]);
            peek(e, v);
            chk("R10 rx entry", v, {24'h0, resp(base + k)});
        end
        chk("R4 release at end", spi_cs_n, 8'hFF);
        clr_done();
        chk("R12 done cleared", grp_done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc, cyc_a, cyc_b, n0;
        void'($urandom(32'd7351));
        for (int i = 0; i < N; i++) begin exp_ctrl[i] = '0; exp_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cs idle", spi_cs_n, 8'hFF);
        chk("R1 sclk low", spi_sclk, 0);
        chk("R1 mosi low", spi_mosi, 0);
        chk("R1 done low", grp_done, 0);
        peek(3, v);
        chk("R1 rx empty", v, 32'h8000_0000);

        // Directed five-byte read command, mode 7, hold on all but last
        wr_ctrl(0, mk(3'd7, 1, 0, 8'hFD, 3'b101));
        wr_ctrl(1, mk(3'd7, 1, 0, 8'hFD, 3'b000));
        wr_ctrl(2, mk(3'd7, 1, 0, 8'hFD, 3'b010));
        wr_ctrl(3, mk(3'd7, 1, 0, 8'hFD, 3'b000));
        wr_ctrl(4, mk(3'd7, 0, 0, 8'hFD, 3'b111));
        wr_data(0, 16'hAB03); wr_data(1, 16'h0001);
        wr_data(2, 16'h7F23); wr_data(3, 16'h0045); wr_data(4, 16'h0000);
        run_group(0, 5, cyc);
        for (int i = 0; i < 5; i++) begin
            rd_rx(i, v);
            chk("R10 full before read", v[31], 0);
            peek(i, v);
            chk("R10 empty after read", v[31:30], 2'b10);
        end

        // R6 stall on missing transmit update
        n0 = nbytes;
        trig(0, 5);
        repeat (200) @(negedge clk);
        chk("R6 stall no bytes", nbytes - n0, 0);
        chk("R6 stall not done", grp_done, 0);
        for (int i = 0; i < 5; i++) wr_data(i, {8'h00, exp_data[i]});
        wait_done(cyc);
        chk("R6 resumed bytes", nbytes - n0, 5);
        clr_done();

        // R6 stall on unread receive entry
        wr_data(0, 16'h0003);
        n0 = nbytes;
        trig(0, 1);
        repeat (200) @(negedge clk);
        chk("R6 rx stall", nbytes - n0, 0);
        rd_rx(0, v);
        wait_done(cyc);
        chk("R6 rx release", nbytes - n0, 1);
        clr_done();
        rd_rx(0, v);

        // R7 mode 4: tx wait, overrun on unread rx
        wr_ctrl(5, mk(3'd4, 0, 0, 8'hFB, 3'b000));
        wr_data(5, 16'h0011);
        trig(5, 1); wait_done(cyc); clr_done();
        wr_data(5, 16'h0022);
        n0 = nbytes;
        trig(5, 1); wait_done(cyc); clr_done();
        peek(5, v);
        chk("R7 overrun set", v, {8'h40, 16'h0, resp(n0)});
        n0 = nbytes;
        trig(5, 1);
        repeat (200) @(negedge clk);
        chk("R7 tx stall", nbytes - n0, 0);
        wr_data(5, 16'h0033);
        wait_done(cyc); clr_done();
        chk("R7 sent new data", log_byte[n0], 8'h33);
        rd_rx(5, v);
        peek(5, v);
        chk("R10 overrun cleared", v[31:30], 2'b10);

        // R8 mode 5: never waits, resends stale data
        wr_ctrl(6, mk(3'd5, 0, 0, 8'h7F, 3'b000));
        wr_data(6, 16'h0044);
        n0 = nbytes;
        trig(6, 1); wait_done(cyc); clr_done();
        trig(6, 1); wait_done(cyc); clr_done();
        chk("R8 two bytes", nbytes - n0, 2);
        chk("R8 stale resend", log_byte[n0 + 1], 8'h44);
        peek(6, v);
        chk("R8 overrun", v[31:30], 2'b01);

        // R9 disabled entry; R5 zero length
        wr_ctrl(7, mk(3'd0, 0, 0, 8'hFE, 3'b000));
        wr_data(7, 16'h0055);
        n0 = nbytes;
        trig(7, 1); wait_done(cyc);
        chk("R9 no bus activity", nbytes - n0, 0);
        peek(7, v);
        chk("R9 rx untouched", v, 32'h8000_0000);
        clr_done();
        trig(0, 0);
        @(negedge clk);
        chk("R5 zero length done", grp_done, 1);
        chk("R5 zero length quiet", nbytes - n0, 0);
        repeat (5) @(negedge clk);
        chk("R12 done sticky", grp_done, 1);
        clr_done();

        // R5 wrap from last entry to entry 0
        rd_rx(0, v);
        wr_ctrl(15, mk(3'd5, 0, 0, 8'hEF, 3'b000)); wr_data(15, 16'h00C1);
        wr_ctrl(0,  mk(3'd5, 0, 0, 8'hDF, 3'b000)); wr_data(0,  16'h00C2);
        run_group(15, 2, cyc);
        rd_rx(15, v); rd_rx(0, v);

        // R11 wait delay with hold
        wr_ctrl(8, mk(3'd5, 1, 0, 8'hFE, 3'b000)); wr_data(8, 16'h0081);
        wr_ctrl(9, mk(3'd5, 0, 0, 8'hFE, 3'b000)); wr_data(9, 16'h0082);
        run_group(8, 2, cyc_a);
        rd_rx(8, v); rd_rx(9, v);
        wr_ctrl(8, mk(3'd5, 1, 1, 8'hFE, 3'b000));
        run_group(8, 2, cyc_b);
        rd_rx(8, v); rd_rx(9, v);
        chk("R11 wait cycles", cyc_b - cyc_a, WAIT);

        // Constrained random groups, modes 5 and 7
        for (int it = 0; it < 20; it++) begin
            int s, l;
            s = int'($urandom % N);
            l = 1 + int'($urandom % 4);
            for (int k = 0; k < l; k++) begin
                int e;
                e = (s + k) % N;
                rd_rx(e, v);
                wr_ctrl(e, mk(($urandom % 2) ? 3'd7 : 3'd5, 1'($urandom % 2), 1'b0,
                              ~(8'h01 << ($urandom % 8)), 3'($urandom % 8)));
                wr_data(e, 16'($urandom));
            end
            run_group(s, l, cyc);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule